// File: doc/BRIEF.md
# Dual-Rate Baud Tick Generator

This block derives two serial bit-rate enables from the bus clock, one for a transmitter and one for a receiver, under a single 8-bit configuration register. A shared first stage divides the bus clock by one of four factors (1, 3, 4 or 13). Two independent second stages then divide the first stage's output by a power of two, from 1 to 128. One stage serves the transmit path and one serves the receive path.

Each rate output is a one-cycle enable at the oversampled rate a UART expects. A second enable per path fires on every sixteenth rate enable and serves as a bit-period strobe. Any register write restarts every counter, so the ticks after a reconfiguration follow the new rate from a known phase. Only enables are produced. No clock is ever switched.

Top module: `dual_rate_tick_gen`

## Requirements
- R1: A write (`cfg_we` high at a rising edge) stores `cfg_wdata`, and `cfg_rdata` shows it from the next cycle on. Without a write, `cfg_rdata` holds its value.
- R2: Bits 7:6 pick the shared first-stage factor P: code 0 gives 1, code 1 gives 3, code 2 gives 4 and code 3 gives 13.
- R3: Bits 5:3 hold the transmit code t. Outside restarts, `tx_tick` repeats every P·2^t cycles.
- R4: Bits 2:0 hold the receive code r. `rx_tick` repeats every P·2^r cycles, independently of the transmit code.
- R5: A rate enable is high for exactly one cycle per period. When the period is 1, it is high in every cycle.
- R6: A write restarts the prescaler, both dividers and both sixteen-tick counters. In the cycle after the write edge, no output is high, even when a tick was due at that edge. The first tick of a path is visible P·2^n cycles after the write edge.
- R7: `tx_bit_tick` and `rx_bit_tick` are high together with every sixteenth tick of their own path, counted from the last restart, and at no other time.
- R8: While `rst_n` is low, all outputs are 0 and the register reads 0. After release, the block runs as if configured with 0, with a tick in every cycle from the first edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read-back |
| tx_tick | output | 1 | Transmit rate enable |
| rx_tick | output | 1 | Receive rate enable |
| tx_bit_tick | output | 1 | Transmit enable on every sixteenth transmit tick |
| rx_bit_tick | output | 1 | Receive enable on every sixteenth receive tick |

## Verification
A register write and a due rate tick can land on the same clock edge. The write must win: the tick is dropped and the period restarts. The bench provokes this by counting cycles from a known write and issuing a second write exactly on the edge where the transmit and receive ticks would fire. It then expects an all-quiet cycle, followed by a full fresh period. The same clash arises many more times between random writes and the running dividers, and each following window is compared cycle by cycle against the period computed from the written fields.

// File: rtl/dual_tick_pkg.sv
package dual_tick_pkg;

    localparam int PRE_SEL_W  = 2;
    localparam int DIV_CODE_W = 3;
    localparam int CFG_W      = PRE_SEL_W + 2 * DIV_CODE_W;
    localparam int PRE_CNT_W  = 4;
    localparam int DIV_CNT_W  = (1 << DIV_CODE_W) - 1;
    localparam int OVS_RATIO  = 16;

    // last count of the shared first stage for each select code
    function automatic logic [PRE_CNT_W-1:0] pre_last(input logic [PRE_SEL_W-1:0] sel);
        case (sel)
            2'd0:    pre_last = 4'd0;
            2'd1:    pre_last = 4'd2;
            2'd2:    pre_last = 4'd3;
            default: pre_last = 4'd12;
        endcase
    endfunction

endpackage

// File: rtl/prescale_stage.sv
module prescale_stage
    import dual_tick_pkg::*;
#(
    parameter int SEL_W = PRE_SEL_W,
    parameter int CNT_W = PRE_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        st_d = st_q;
        last = CNT_W'(pre_last(sel));
        wrap = (st_q.cnt == last);
        if (restart) begin
            st_d.cnt = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rate_chain.sv
module rate_chain
    import dual_tick_pkg::*;
#(
    parameter int CODE_W = DIV_CODE_W,
    parameter int CNT_W  = DIV_CNT_W,
    parameter int OVS    = OVS_RATIO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              pre_wrap,
    input  logic [CODE_W-1:0] code,
    output logic              tick,
    output logic              bit_tick
);

    localparam int OVS_W = $clog2(OVS);

    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic [OVS_W-1:0] ovs;
        logic             tick;
        logic             bit_tick;
    } chain_state_t;

    chain_state_t st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic advance, at_lim, fire, ovs_last;

    always_comb begin
        st_d     = st_q;
        lim      = CNT_W'((32'd1 << code) - 32'd1);
        advance  = pre_wrap & ~restart;
        at_lim   = (st_q.div == lim);
        fire     = advance & at_lim;
        ovs_last = (st_q.ovs == OVS_W'(OVS - 1));

        st_d.tick     = fire;
        st_d.bit_tick = fire & ovs_last;

        if (restart) begin
            st_d.div = '0;
            st_d.ovs = '0;
        end else if (advance) begin
            st_d.div = at_lim ? '0 : st_q.div + 1'b1;
            if (fire) begin
                st_d.ovs = ovs_last ? '0 : st_q.ovs + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick     = st_q.tick;
    assign bit_tick = st_q.bit_tick;

endmodule

// File: rtl/dual_rate_tick_gen.sv
module dual_rate_tick_gen
    import dual_tick_pkg::*;
#(
    parameter int SEL_W  = PRE_SEL_W,
    parameter int CODE_W = DIV_CODE_W,
    parameter int OVS    = OVS_RATIO
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [SEL_W+2*CODE_W-1:0]   cfg_wdata,
    output logic [SEL_W+2*CODE_W-1:0]   cfg_rdata,
    output logic                        tx_tick,
    output logic                        rx_tick,
    output logic                        tx_bit_tick,
    output logic                        rx_bit_tick
);

    localparam int CW      = SEL_W + 2 * CODE_W;
    localparam int PRE_LSB = 2 * CODE_W;
    localparam int TX_LSB  = CODE_W;
    localparam int RX_LSB  = 0;
    localparam int N_CH    = 2;
    localparam int CNT_W   = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [CW-1:0] cfg;
    } top_state_t;

    top_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.cfg = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata = st_q.cfg;

    logic pre_wrap;

    prescale_stage #(
        .SEL_W (SEL_W),
        .CNT_W (PRE_CNT_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_we),
        .sel     (st_q.cfg[CW-1:PRE_LSB]),
        .wrap    (pre_wrap)
    );

    logic [CODE_W-1:0] ch_code [N_CH];
    logic [N_CH-1:0]   ch_tick;
    logic [N_CH-1:0]   ch_bit;

    assign ch_code[0] = st_q.cfg[TX_LSB +: CODE_W];
    assign ch_code[1] = st_q.cfg[RX_LSB +: CODE_W];

    for (genvar c = 0; c < N_CH; c++) begin : g_chain
        rate_chain #(
            .CODE_W (CODE_W),
            .CNT_W  (CNT_W),
            .OVS    (OVS)
        ) u_chain (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (cfg_we),
            .pre_wrap (pre_wrap),
            .code     (ch_code[c]),
            .tick     (ch_tick[c]),
            .bit_tick (ch_bit[c])
        );
    end

    assign tx_tick     = ch_tick[0];
    assign rx_tick     = ch_tick[1];
    assign tx_bit_tick = ch_bit[0];
    assign rx_bit_tick = ch_bit[1];

endmodule

module dual_rate_tick_chk #(
    parameter int SEL_W  = 2,
    parameter int CODE_W = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [SEL_W+2*CODE_W-1:0] cfg_wdata,
    input logic [SEL_W+2*CODE_W-1:0] cfg_rdata,
    input logic                      tx_tick,
    input logic                      rx_tick,
    input logic                      tx_bit_tick,
    input logic                      rx_bit_tick
);

    localparam int CW = SEL_W + 2 * CODE_W;

    logic tx_full_rate;
    assign tx_full_rate = (cfg_rdata[CW-1 -: SEL_W] == '0) && (cfg_rdata[CODE_W +: CODE_W] == '0);

    // R1
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !tx_tick && !rx_tick && !tx_bit_tick && !rx_bit_tick);

    // R7
    tx_bit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_tick |-> tx_tick);

    // R7
    rx_bit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_tick |-> rx_tick);

    // R5
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick && !tx_full_rate |=> !tx_tick);

    // R2
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we && cfg_rdata == '0 |=> tx_tick && rx_tick);

    // R8
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!tx_tick && !rx_tick && !tx_bit_tick && !rx_bit_tick && cfg_rdata == '0);
        end
    end

endmodule

bind dual_rate_tick_gen dual_rate_tick_chk #(
    .SEL_W  (SEL_W),
    .CODE_W (CODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .tx_tick     (tx_tick),
    .rx_tick     (rx_tick),
    .tx_bit_tick (tx_bit_tick),
    .rx_bit_tick (rx_bit_tick)
);

// File: tb/dual_rate_tick_gen_test.sv
module dual_rate_tick_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       tx_tick, rx_tick, tx_bit_tick, rx_bit_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_rate_tick_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .tx_tick     (tx_tick),
        .rx_tick     (rx_tick),
        .tx_bit_tick (tx_bit_tick),
        .rx_bit_tick (rx_bit_tick)
    );

    // R2: first-stage factor from bits 7:6
    function automatic int pre_factor(input logic [7:0] v);
        case (v[7:6])
            2'd0:    return 1;
            2'd1:    return 3;
            2'd2:    return 4;
            default: return 13;
        endcase
    endfunction

    function automatic int tx_period(input logic [7:0] v);
        return pre_factor(v) * (1 << v[5:3]);
    endfunction

    function automatic int rx_period(input logic [7:0] v);
        return pre_factor(v) * (1 << v[2:0]);
    endfunction

    task automatic check(input string tag, input int j, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, j, act, exp);
        end
    endtask

    // called at a negedge; write edge is the next posedge; returns at the negedge after it
    task automatic do_write(input logic [7:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
        check("R1 readback", 0, cfg_rdata, v);
        check("R6 quiet after write", 0, {tx_tick, rx_tick, tx_bit_tick, rx_bit_tick}, 0);
    endtask

    // samples j = 1..len cycles after the restart edge
    task automatic run_window(input logic [7:0] v, input int len, input string ttag);
        int pt, pr;
        pt = tx_period(v);
        pr = rx_period(v);
        for (int j = 1; j <= len; j++) begin
            @(negedge clk);
            check({ttag, " R3 R5 tx_tick"}, j, tx_tick, (j % pt) == 0);
            check({ttag, " R4 R5 rx_tick"}, j, rx_tick, (j % pr) == 0);
            check("R7 tx_bit_tick", j, tx_bit_tick, (j % (16 * pt)) == 0);
            check("R7 rx_bit_tick", j, rx_bit_tick, (j % (16 * pr)) == 0);
        end
    endtask

    function automatic int win_len(input logic [7:0] v);
        int m;
        m = (tx_period(v) > rx_period(v)) ? tx_period(v) : rx_period(v);
        if (16 * m + 2 <= 1500) return 16 * m + 2;
        return 2 * m + 3;
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual hung expected done");
        finish_up();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd5813));

        // R8: reset state
        repeat (4) @(negedge clk);
        check("R8 reset outputs", 0, {tx_tick, rx_tick, tx_bit_tick, rx_bit_tick}, 0);
        check("R8 reset register", 0, cfg_rdata, 0);
        rst_n = 1'b1;
        run_window(8'h00, 40, "R8");

        // R2: each first-stage factor with unit divisors
        for (int s = 0; s < 4; s++) begin
            v = 8'(s << 6);
            do_write(v);
            run_window(v, win_len(v), "R2");
        end

        // R3 R4: independent divisors, including the extremes
        do_write(8'h0A);
        run_window(8'h0A, win_len(8'h0A), "R3");
        do_write(8'h3F);
        run_window(8'h3F, win_len(8'h3F), "R4");
        do_write(8'hF8);
        run_window(8'hF8, win_len(8'hF8), "R3");
        do_write(8'hC7);
        run_window(8'hC7, win_len(8'hC7), "R4");

        // R6: write on the exact edge where both ticks are due
        v = 8'h48;
        do_write(v);
        for (int j = 1; j < tx_period(v); j++) @(negedge clk);
        do_write(v);
        run_window(v, win_len(v), "R6");

        // random configurations
        for (int k = 0; k < 20; k++) begin
            v = 8'($urandom);
            do_write(v);
            run_window(v, win_len(v), "R6");
        end

        finish_up();
    end

endmodule